// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block decides when a successive-approximation converter samples and converts, and which result slot each conversion fills. Software-style configuration arrives as one write strobe that carries an enable-conversion bit and the locked fields: the clock divide, the sequence mode, the sample mode, two sample-time codes, a start slot and a 32-bit end-of-sequence mask. A start trigger (pulse sampling) or a rising edge on the external sample input (extended sampling) begins a step. The block then raises the sample-control output, pulses a conversion start, waits for the converter's done strobe and stores the returned word in a bank of result slots.

In pulse sampling, the sample window is a whole number of divided-clock periods taken from an encoded table. The code used depends on which slot the step converts. In extended sampling, the window follows the external pulse. The four sequence modes choose between one slot and a run of slots, and between a one-shot run and a run that re-arms on each trigger. Results leave through a plain read port. The bank takes every write, so there is no back-pressure anywhere: the converter's done strobe is a one-cycle event that must always be accepted, and reads are combinational.

Top module: `adc_seq_ctrl`

## Requirements
- R1: In pulse sampling, the sample-control output stays high for N x (D+1) clock cycles. D is the 3-bit divide field (0..7) and N is the decoded sample length.
- R2: Sample-time codes decode to divided-clock periods as 0=4, 1=8, 2=16, 3=32, 4=64, 5=96, 6=128 and 7=192. Every code from 8 to 15 decodes as 192.
- R3: Steps on slots 8 to 23 use the high-range sample code. Steps on slots 0 to 7 and 24 to 31 use the low-range code.
- R4: While the enable bit is 1, a configuration write changes only the enable bit. All other fields keep their values.
- R5: Mode 00 (single slot, one shot) converts the start slot once. Later triggers are ignored until the enable bit has been cleared and set again.
- R6: Mode 01 (sequence, one shot) converts the start slot and each following slot in turn, up to and including the first slot whose end-of-sequence mask bit is 1. Slot 31 is followed by slot 0.
- R7: Mode 10 (repeat single slot) converts the start slot again on every trigger. Busy is low between triggers.
- R8: Mode 11 (repeat sequence) runs the whole sequence of R6 again on every trigger.
- R9: In extended sampling, the sample-control output is the external sample input delayed by one cycle. It has the same width, and the conversion starts when that input falls.
- R10: Busy is high during every sample, conversion and multi-step run, and low otherwise.
- R11: Clearing the enable bit in the middle of a run lets the current step finish and store its result. The run then stops and busy drops on the done strobe.
- R12: Conversion start is a one-cycle pulse in the first cycle after the sample-control output falls. The stored word appears on the read port in the cycle after the done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enc | input | 1 | Enable-conversion bit (always writable) |
| cfg_div | input | 3 | Divide field, divides by value+1 |
| cfg_mode | input | 2 | Sequence mode |
| cfg_pulse | input | 1 | 1 selects pulse sampling, 0 selects extended sampling |
| cfg_sht_lo | input | 4 | Sample code for slots 0-7 and 24-31 |
| cfg_sht_hi | input | 4 | Sample code for slots 8-23 |
| cfg_start | input | 5 | First slot of a run |
| cfg_eos | input | 32 | End-of-sequence mask, one bit per slot |
| trig | input | 1 | Start trigger for pulse sampling |
| samp_in | input | 1 | External sample input |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter result, valid with conv_done |
| rd_addr | input | 5 | Result slot read address |
| conv_start | output | 1 | Converter start pulse |
| samp_ctrl | output | 1 | Sample-control output |
| busy | output | 1 | Activity flag |
| cur_slot | output | 5 | Slot of the current step |
| rd_data | output | 12 | Result slot read data |

## Verification
A trigger registered at one edge raises sample-control and busy at that same edge. Sample-control then stays high for exactly N x (D+1) cycles, or for the external pulse width. The bench counts its width one falling edge at a time and expects conversion start at the first falling edge where sample-control is low. The converter model answers a fixed four cycles after it sees the start pulse. Busy and the bank are updated at the edge that takes the done strobe, so the bench reads results and checks that busy has dropped only after the last done strobe, and it waits out ten idle cycles before it concludes that a trigger was ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMP,
    ST_XSAMP,
    ST_CONV,
    ST_ARM
  } seq_state_e;

  localparam int LEN_W = 8;

  // decoded sample length in divided-clock periods; reserved codes saturate
  function automatic logic [LEN_W-1:0] sht_len(input logic [3:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      4'd0:    n = 8'd4;
      4'd1:    n = 8'd8;
      4'd2:    n = 8'd16;
      4'd3:    n = 8'd32;
      4'd4:    n = 8'd64;
      4'd5:    n = 8'd96;
      4'd6:    n = 8'd128;
      default: n = 8'd192;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = !clr && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || tick) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_sample_timer.sv
module adc_sample_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic [LEN_W-1:0] tcnt_q;

  assign done = run && tick && (tcnt_q == len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) tcnt_q <= '0;
    else if (tick)      tcnt_q <= tcnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   mem_q[g] <= '0;
      else if (wr_en && wr_addr == SLOT_W'(g))      mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 12,
  parameter int DIV_W     = 3,
  parameter int HI_FIRST  = 8,
  parameter int HI_LAST   = 23,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_enc,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_pulse,
  input  logic [3:0]           cfg_sht_lo,
  input  logic [3:0]           cfg_sht_hi,
  input  logic [SLOT_W-1:0]    cfg_start,
  input  logic [NUM_SLOTS-1:0] cfg_eos,
  input  logic                 trig,
  input  logic                 samp_in,
  input  logic                 conv_done,
  input  logic [DATA_W-1:0]    conv_data,
  input  logic [SLOT_W-1:0]    rd_addr,
  output logic                 conv_start,
  output logic                 samp_ctrl,
  output logic                 busy,
  output logic [SLOT_W-1:0]    cur_slot,
  output logic [DATA_W-1:0]    rd_data
);
  localparam logic [SLOT_W-1:0] HI_A  = SLOT_W'(HI_FIRST);
  localparam logic [SLOT_W-1:0] HI_B  = SLOT_W'(HI_LAST);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(NUM_SLOTS - 1);

  // configuration, locked while enabled
  logic                 enc_q, pulse_q;
  logic [DIV_W-1:0]     div_q;
  logic [1:0]           mode_q;
  logic [3:0]           sht_lo_q, sht_hi_q;
  logic [SLOT_W-1:0]    start_q;
  logic [NUM_SLOTS-1:0] eos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_q    <= 1'b0;
      pulse_q  <= 1'b0;
      div_q    <= '0;
      mode_q   <= 2'b00;
      sht_lo_q <= '0;
      sht_hi_q <= '0;
      start_q  <= '0;
      eos_q    <= '0;
    end else if (cfg_we) begin
      enc_q <= cfg_enc;
      if (!enc_q) begin
        pulse_q  <= cfg_pulse;
        div_q    <= cfg_div;
        mode_q   <= cfg_mode;
        sht_lo_q <= cfg_sht_lo;
        sht_hi_q <= cfg_sht_hi;
        start_q  <= cfg_start;
        eos_q    <= cfg_eos;
      end
    end
  end

  // sequencer state
  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              armed_q, conv_start_q, samp_q;
  logic              samp_rise, step_last, in_hi, tick, tmr_done, run;
  logic [LEN_W-1:0]  len;

  assign samp_rise = samp_in && !samp_q;
  assign in_hi     = (slot_q >= HI_A) && (slot_q <= HI_B);
  assign len       = sht_len(in_hi ? sht_hi_q : sht_lo_q);
  assign step_last = !mode_q[0] || eos_q[slot_q];
  assign run       = (state_q == ST_SAMP);

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!run),
    .div  (div_q),
    .tick (tick)
  );

  adc_sample_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick),
    .len  (len),
    .done (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      slot_q       <= '0;
      armed_q      <= 1'b1;
      conv_start_q <= 1'b0;
    end else begin
      conv_start_q <= 1'b0;
      if (!enc_q) armed_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (enc_q && armed_q && (pulse_q ? trig : samp_rise)) begin
            slot_q  <= start_q;
            state_q <= pulse_q ? ST_SAMP : ST_XSAMP;
          end
        end
        ST_SAMP: begin
          if (tmr_done) begin
            state_q      <= ST_CONV;
            conv_start_q <= 1'b1;
          end
        end
        ST_XSAMP: begin
          if (!samp_in) begin
            state_q      <= ST_CONV;
            conv_start_q <= 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            if (!enc_q) begin
              state_q <= ST_IDLE;
            end else if (step_last) begin
              state_q <= ST_IDLE;
              if (!mode_q[1]) armed_q <= 1'b0;
            end else begin
              slot_q  <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
              state_q <= pulse_q ? ST_SAMP : ST_ARM;
            end
          end
        end
        ST_ARM: begin
          if (!enc_q)         state_q <= ST_IDLE;
          else if (samp_rise) state_q <= ST_XSAMP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  adc_result_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (state_q == ST_CONV && conv_done),
    .wr_addr(slot_q),
    .wr_data(conv_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  assign conv_start = conv_start_q;
  assign samp_ctrl  = (state_q == ST_SAMP) || (state_q == ST_XSAMP);
  assign busy       = (state_q != ST_IDLE);
  assign cur_slot   = slot_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             samp_ctrl,
  input logic             conv_start,
  input logic             conv_done,
  input logic             conv_wait,
  input logic             enc_q,
  input logic [DIV_W-1:0] div_q,
  input logic [1:0]       mode_q
);
  // R12
  fell_samp_starts_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_ctrl) |-> conv_start);

  // R12
  conv_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R10
  busy_covers_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_ctrl || conv_start) |-> busy);

  // R10
  busy_rise_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> samp_ctrl);

  // R4
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enc_q) |-> ($stable(div_q) && $stable(mode_q)));

  // R11
  stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_wait && conv_done && !enc_q) |=> !busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .samp_ctrl (samp_ctrl),
  .conv_start(conv_start),
  .conv_done (conv_done),
  .conv_wait (state_q == adc_seq_pkg::ST_CONV),
  .enc_q     (enc_q),
  .div_q     (div_q),
  .mode_q    (mode_q)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_enc = 0, cfg_pulse = 0;
  logic [2:0]  cfg_div = 0;
  logic [1:0]  cfg_mode = 0;
  logic [3:0]  cfg_sht_lo = 0, cfg_sht_hi = 0;
  logic [4:0]  cfg_start = 0, rd_addr = 0;
  logic [31:0] cfg_eos = 0;
  logic        trig = 0, samp_in = 0, conv_done = 0;
  logic [11:0] conv_data = 0;
  logic        conv_start, samp_ctrl, busy;
  logic [4:0]  cur_slot;
  logic [11:0] rd_data;

  int errors = 0, checks = 0;
  int n_start = 0, n_done = 0, cd = 0;
  logic [4:0] slot_log [256];

  always #2.5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enc(cfg_enc), .cfg_div(cfg_div),
    .cfg_mode(cfg_mode), .cfg_pulse(cfg_pulse), .cfg_sht_lo(cfg_sht_lo),
    .cfg_sht_hi(cfg_sht_hi), .cfg_start(cfg_start), .cfg_eos(cfg_eos), .trig(trig),
    .samp_in(samp_in), .conv_done(conv_done), .conv_data(conv_data), .rd_addr(rd_addr),
    .conv_start(conv_start), .samp_ctrl(samp_ctrl), .busy(busy), .cur_slot(cur_slot),
    .rd_data(rd_data)
  );

  function automatic int ncyc(input int code);
    case (code)
      0: return 4;   1: return 8;   2: return 16;  3: return 32;
      4: return 64;  5: return 96;  6: return 128; default: return 192;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: done strobe four cycles after the start pulse
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        slot_log[n_start % 256] = cur_slot;
        n_start++;
        cd = 4;
      end else if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          conv_done = 1'b1;
          conv_data = 12'(12'h100 + n_done);
          n_done++;
        end
      end
    end
  end

  task automatic cfg(input int div, input int mode, input bit pulse, input int lo,
                     input int hi, input int start, input logic [31:0] eos);
    @(negedge clk);
    cfg_we = 1; cfg_enc = 0;
    @(negedge clk);
    cfg_enc = 1; cfg_div = 3'(div); cfg_mode = 2'(mode); cfg_pulse = pulse;
    cfg_sht_lo = 4'(lo); cfg_sht_hi = 4'(hi); cfg_start = 5'(start); cfg_eos = eos;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fire();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic measure(output int len);
    while (!samp_ctrl) @(negedge clk);
    len = 0;
    while (samp_ctrl) begin
      chk(busy === 1'b1, "R10 busy during sample", busy, 1);
      len++;
      @(negedge clk);
    end
    chk(conv_start === 1'b1, "R12 start after sample", conv_start, 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_addr = 5'(a); #1; v = int'(rd_data);
  endtask

  initial begin
    int len, v, base;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && samp_ctrl === 1'b0 && conv_start === 1'b0, "R10 reset idle", busy, 0);
    rd(0, v); chk(v == 0, "R12 bank reset", v, 0);

    // R5 single shot, code 0, divide by 1, slot 0
    cfg(0, 0, 1, 0, 5, 0, 0);
    base = n_done;
    fire(); measure(len); chk(len == 4, "R1 R2 code0 div1", len, 4);
    wait_idle();
    rd(0, v); chk(v == 12'h100 + base, "R12 stored result", v, 12'h100 + base);
    fire(); repeat (10) @(negedge clk);
    chk(busy === 1'b0 && n_start == base + 1, "R5 retrigger ignored", n_start, base + 1);
    cfg(0, 0, 1, 0, 5, 0, 0);
    fire(); measure(len); wait_idle();
    chk(n_done == base + 2, "R5 rearm after enable toggle", n_done, base + 2);

    // R3 slot range boundaries: low code 0 (4), high code 1 (8)
    foreach (slot_log[i]) if (i < 4) begin
      int s, e;
      s = (i == 0) ? 7 : (i == 1) ? 8 : (i == 2) ? 23 : 24;
      e = (s >= 8 && s <= 23) ? 8 : 4;
      cfg(1, 0, 1, 0, 1, s, 0);
      fire(); measure(len); wait_idle();
      chk(len == e * 2, "R3 slot range code", len, e * 2);
    end

    // R2 reserved code saturates at 192
    cfg(0, 0, 1, 11, 0, 0, 0);
    fire(); measure(len); wait_idle();
    chk(len == 192, "R2 reserved code", len, 192);

    // R1 R2 R3 random configurations
    for (int k = 0; k < 12; k++) begin
      int d, lo, hi, s, e;
      d = $urandom % 8; lo = $urandom % 16; hi = $urandom % 16; s = $urandom % 32;
      e = ncyc((s >= 8 && s <= 23) ? hi : lo) * (d + 1);
      cfg(d, 0, 1, lo, hi, s, 0);
      fire(); measure(len); wait_idle();
      chk(len == e, "R1 random sample length", len, e);
    end

    // R4 locked write ignored while enabled
    cfg(0, 0, 1, 0, 0, 0, 0);
    @(negedge clk); cfg_we = 1; cfg_enc = 1; cfg_div = 3'd7; cfg_sht_lo = 4'd7;
    @(negedge clk); cfg_we = 0;
    fire(); measure(len); wait_idle();
    chk(len == 4, "R4 locked fields kept", len, 4);

    // R6 sequence with wrap 30,31,0,1
    cfg(0, 1, 1, 0, 0, 30, 32'h2);
    base = n_start;
    fire(); wait_idle();
    chk(n_start == base + 4, "R6 sequence length", n_start, base + 4);
    for (int j = 0; j < 4; j++) begin
      int es;
      es = (30 + j) % 32;
      chk(int'(slot_log[(base + j) % 256]) == es, "R6 slot order", slot_log[(base + j) % 256], es);
      rd(es, v); chk(v == 12'h100 + base + j, "R6 stored word", v, 12'h100 + base + j);
    end

    // R7 repeat single slot
    cfg(0, 2, 1, 0, 0, 5, 0);
    base = n_start;
    fire(); wait_idle();
    chk(busy === 1'b0, "R7 busy low between triggers", busy, 0);
    fire(); wait_idle();
    chk(n_start == base + 2, "R7 two conversions", n_start, base + 2);
    rd(5, v); chk(v == 12'h100 + base + 1, "R7 latest word", v, 12'h100 + base + 1);

    // R8 repeat sequence 3,4 twice
    cfg(0, 3, 1, 0, 0, 3, 32'h10);
    base = n_start;
    fire(); wait_idle(); fire(); wait_idle();
    chk(n_start == base + 4, "R8 repeated runs", n_start, base + 4);
    chk(slot_log[(base + 2) % 256] == 5'd3, "R8 restart slot", slot_log[(base + 2) % 256], 3);

    // R9 extended sampling, 17-cycle external pulse on slot 2
    cfg(0, 0, 0, 0, 0, 2, 0);
    base = n_done;
    fork
      begin
        @(negedge clk); samp_in = 1;
        repeat (17) @(negedge clk);
        samp_in = 0;
      end
      measure(len);
    join
    wait_idle();
    chk(len == 17, "R9 window width", len, 17);
    rd(2, v); chk(v == 12'h100 + base, "R9 stored word", v, 12'h100 + base);

    // R11 disable during repeat sequence 10..15
    cfg(0, 3, 1, 0, 0, 10, 32'h8000);
    base = n_start;
    fire();
    while (n_start < base + 2) @(negedge clk);
    cfg_we = 1; cfg_enc = 0;
    @(negedge clk); cfg_we = 0;
    wait_idle();
    chk(n_start == base + 2 && n_done == base + 2, "R11 stop after current", n_done, base + 2);
    chk(slot_log[(base + 1) % 256] == 5'd11, "R11 last slot", slot_log[(base + 1) % 256], 11);
    rd(11, v); chk(v == 12'h100 + base + 1, "R11 final word stored", v, 12'h100 + base + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule